// File: doc/BRIEF.md
# Static Dataflow Firing Scheduler

This block issues one-cycle fire strobes for two actors of a fixed two-actor multirate dataflow graph. The producer makes one data word per firing and the consumer takes a batch of `REPS` words per firing. The firing pattern is fixed when the design is built and repeats for as long as the block is enabled. No handshake runs between the two actors. Each actor fires only when the schedule says so, and a correct schedule keeps the buffer between them from running over or running dry. One dataflow time unit is one clock cycle, and every firing takes exactly one cycle.

The buffer depth chooses the schedule. If the depth equals `REPS`, the schedule is serial. The producer fires `REPS` times, then the consumer fires once on its own, and the period is `REPS+1` enabled cycles. If the depth is at least `REPS+1`, the producer fires in every enabled cycle. The consumer then fires together with the producer once every `REPS` enabled cycles. In this overlapped mode each actor keeps a fixed period of its own, and throughput goes up by one firing per period.

An enable input holds the schedule position. A sticky flag reports any firing that finds the buffer full or short of a batch.

Top module: `sdf_fire_sched`

## Requirements
- R1: While reset is asserted, and right after it, `occupancy` reads 0 and `sched_err` reads 0. No fire strobe is high while `en` is low.
- R2: The first enabled cycle after reset fires the producer only.
- R3: When `BUF_DEPTH == REPS` (serial mode), enabled cycles form a repeating period of `REPS+1`. The producer fires in the first `REPS` cycles of each period and the consumer fires in the last one. The two strobes are never high in the same cycle.
- R4: When `BUF_DEPTH > REPS` (overlapped mode), the producer fires in every enabled cycle. Counting enabled cycles from 0 after reset, the consumer fires at indices `REPS`, `2*REPS`, `3*REPS` and so on, in the same cycle as the producer.
- R5: A cycle with `en` low fires nothing and moves the schedule on by nothing. The pattern resumes where it stopped, and only enabled cycles are counted.
- R6: During a consumer firing, lane k of `cons_data` (bits `k*DATA_W` upward) holds the k-th oldest buffered word, with k = 0 the oldest. Those `REPS` words leave the buffer. `occupancy` equals `REPS` whenever the consumer fires.
- R7: After each clock edge, `occupancy` equals its previous value, plus 1 if the producer fired, minus `REPS` if the consumer fired. It never exceeds `REPS`.
- R8: `sched_err` is sticky until reset. It stays 0 for as long as the built-in schedule runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Schedule advance enable |
| prod_data | input | DATA_W | Word buffered when the producer fires |
| fire_a | output | 1 | Producer fire strobe |
| fire_b | output | 1 | Consumer fire strobe |
| cons_data | output | REPS*DATA_W | Batch of oldest words, valid while fire_b is high |
| occupancy | output | $clog2(BUF_DEPTH+1) | Words currently buffered |
| sched_err | output | 1 | Sticky full-or-short firing flag |

## Verification
The overlapped instance is driven from a vector table that mixes isolated idle cycles, back-to-back idle cycles and long enabled runs. Comparing its strobes cycle by cycle separates a schedule that counts only enabled cycles from one that counts clock edges, and shows whether a consumer firing lands on the right multiple of `REPS`. A second instance is built in serial mode and run with an irregular enable pattern. It shows the producer's alternating gaps and the strict exclusion of the two strobes. Every consumer batch is compared lane by lane against a record of the pushed words, which exposes order or wrap errors. A mid-run reset checks that the schedule restarts with the producer alone.

// File: rtl/sdf_sched_pkg.sv
package sdf_sched_pkg;

  typedef enum logic {
    SCHED_SERIAL  = 1'b0,
    SCHED_OVERLAP = 1'b1
  } sched_kind_e;

  // Width of a counter that must hold values 0 .. v-1 (at least one bit).
  function automatic int unsigned cnt_w(input int unsigned v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

  // A spare slot beyond one batch lets producer and consumer overlap.
  function automatic sched_kind_e pick_kind(input int unsigned reps,
                                            input int unsigned depth);
    return (depth > reps) ? SCHED_OVERLAP : SCHED_SERIAL;
  endfunction

endpackage

// File: rtl/sdf_fire_gen.sv
module sdf_fire_gen
  import sdf_sched_pkg::*;
#(
  parameter int unsigned REPS    = 4,
  parameter bit          OVERLAP = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic fire_a,
  output logic fire_b
);

  localparam int unsigned     PERIOD  = OVERLAP ? REPS : REPS + 1;
  localparam int unsigned     PH_W    = cnt_w(PERIOD);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);

  logic [PH_W-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (en) begin
      ph_d = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (en) begin
      ph_q <= ph_d;
    end
  end

  generate
    if (OVERLAP) begin : g_overlap
      // Consumer waits for the first full batch, then keeps a fixed period.
      logic warm_q, warm_d;

      always_comb begin
        warm_d = warm_q | (ph_q == PH_LAST);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          warm_q <= 1'b0;
        end else if (en) begin
          warm_q <= warm_d;
        end
      end

      assign fire_a = en;
      assign fire_b = en & warm_q & (ph_q == '0);
    end else begin : g_serial
      assign fire_a = en & (ph_q != PH_LAST);
      assign fire_b = en & (ph_q == PH_LAST);

      p_mutex_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire_a && fire_b))
        else $error("R3: producer and consumer fired together");
    end
  endgenerate

endmodule

// File: rtl/sdf_batch_fifo.sv
module sdf_batch_fifo
  import sdf_sched_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 5,
  parameter int unsigned POP_N  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [DATA_W-1:0]            push_data,
  input  logic                         pop,
  output logic [POP_N*DATA_W-1:0]      batch_data,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         ovf,
  output logic                         udf
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned PTR_W = cnt_w(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0]  count_q, count_d;
  logic              full, lack, do_push, do_pop;

  function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p,
                                           input int unsigned step);
    int unsigned s;
    s = 32'(p) + step;
    if (s >= DEPTH) s = s - DEPTH;
    return PTR_W'(s);
  endfunction

  assign full    = (count_q == CNT_W'(DEPTH));
  assign lack    = (count_q <  CNT_W'(POP_N));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~lack;

  always_comb begin
    wr_d    = do_push ? adv(wr_q, 1) : wr_q;
    rd_d    = do_pop ? adv(rd_q, POP_N) : rd_q;
    count_d = count_q + CNT_W'(do_push) - (do_pop ? CNT_W'(POP_N) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
    end else if (push | pop) begin
      wr_q    <= wr_d;
      rd_q    <= rd_d;
      count_q <= count_d;
    end
  end

  // Storage has no reset; only written slots are ever read out.
  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[wr_q] <= push_data;
    end
  end

  generate
    for (genvar k = 0; k < POP_N; k++) begin : g_lane
      logic [PTR_W-1:0] idx;
      assign idx = adv(rd_q, k);
      assign batch_data[k*DATA_W +: DATA_W] = mem[idx];
    end
  endgenerate

  assign count = count_q;
  assign ovf   = push & full;
  assign udf   = pop & lack;

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full)
    else $error("R8: producer fired into a full buffer");

  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !lack)
    else $error("R8: consumer fired without a full batch");

endmodule

// File: rtl/sdf_err_latch.sv
module sdf_err_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  output logic flag
);

  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (set) begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> flag_q)
    else $error("R8: error flag cleared without reset");

endmodule

// File: rtl/sdf_fire_sched.sv
module sdf_fire_sched
  import sdf_sched_pkg::*;
#(
  parameter int unsigned REPS      = 4,
  parameter int unsigned BUF_DEPTH = 5,
  parameter int unsigned DATA_W    = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             en,
  input  logic [DATA_W-1:0]                prod_data,
  output logic                             fire_a,
  output logic                             fire_b,
  output logic [REPS*DATA_W-1:0]           cons_data,
  output logic [$clog2(BUF_DEPTH+1)-1:0]   occupancy,
  output logic                             sched_err
);

  localparam sched_kind_e KIND  = pick_kind(REPS, BUF_DEPTH);
  localparam bit          OVL   = (KIND == SCHED_OVERLAP);
  localparam int unsigned OCC_W = $clog2(BUF_DEPTH + 1);

  logic ovf, udf;

  sdf_fire_gen #(
    .REPS    (REPS),
    .OVERLAP (OVL)
  ) u_gen (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .fire_a (fire_a),
    .fire_b (fire_b)
  );

  sdf_batch_fifo #(
    .DATA_W (DATA_W),
    .DEPTH  (BUF_DEPTH),
    .POP_N  (REPS)
  ) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (fire_a),
    .push_data  (prod_data),
    .pop        (fire_b),
    .batch_data (cons_data),
    .count      (occupancy),
    .ovf        (ovf),
    .udf        (udf)
  );

  sdf_err_latch u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ovf | udf),
    .flag  (sched_err)
  );

  p_occ_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= OCC_W'(REPS))
    else $error("R7: occupancy above one batch");

  p_batch_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire_b |-> (occupancy == OCC_W'(REPS)))
    else $error("R6: consumer fired without exactly one batch buffered");

endmodule

// File: tb/sdf_fire_sched_tb.sv
module sdf_fire_sched_tb;

  localparam int unsigned N_O = 4, D_O = 5, N_S = 3, D_S = 3, DW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, en_o, en_s;
  logic [DW-1:0] pd_o, pd_s;
  logic fa_o, fb_o, err_o, fa_s, fb_s, err_s;
  logic [N_O*DW-1:0] cons_o;
  logic [N_S*DW-1:0] cons_s;
  logic [2:0] occ_o;
  logic [1:0] occ_s;

  sdf_fire_sched #(.REPS(N_O), .BUF_DEPTH(D_O), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en_o), .prod_data(pd_o),
    .fire_a(fa_o), .fire_b(fb_o), .cons_data(cons_o),
    .occupancy(occ_o), .sched_err(err_o));

  sdf_fire_sched #(.REPS(N_S), .BUF_DEPTH(D_S), .DATA_W(DW)) u_dut_seq (
    .clk(clk), .rst_n(rst_n), .en(en_s), .prod_data(pd_s),
    .fire_a(fa_s), .fire_b(fb_s), .cons_data(cons_s),
    .occupancy(occ_s), .sched_err(err_s));

  // {en, expected fire_a, expected fire_b}, overlapped instance, REPS=4
  localparam logic [2:0] VEC_O [18] = '{
    3'b110, 3'b110, 3'b110, 3'b000, 3'b110, 3'b111, 3'b110, 3'b000, 3'b000,
    3'b110, 3'b110, 3'b111, 3'b110, 3'b110, 3'b110, 3'b111, 3'b110, 3'b000};

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [DW-1:0] hist_o [0:1023];
  logic [DW-1:0] hist_s [0:1023];
  int wr_o = 0, rd_o = 0, te_o = 0;
  int wr_s = 0, rd_s = 0, te_s = 0;

  task automatic check(input bit ok, input string req, input longint act,
                       input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step_o(input logic e, input logic xa, input logic xb,
                        input string req);
    @(negedge clk);
    en_o = e;
    pd_o = 8'(wr_o * 7 + 3);
    #1;
    check(occ_o == 3'(wr_o - rd_o), "R7 occupancy", occ_o, wr_o - rd_o);
    check(occ_o <= 3'(N_O), "R7 occupancy bound", occ_o, N_O);
    check(err_o == 1'b0, "R8 error flag", err_o, 0);
    check(fa_o == xa, {req, " fire_a"}, fa_o, xa);
    check(fb_o == xb, {req, " fire_b"}, fb_o, xb);
    if (xb) begin
      check(occ_o == 3'(N_O), "R6 batch ready", occ_o, N_O);
      for (int k = 0; k < N_O; k++)
        check(cons_o[k*DW +: DW] == hist_o[rd_o + k], "R6 batch lane",
              cons_o[k*DW +: DW], hist_o[rd_o + k]);
    end
    @(posedge clk);
    if (xa) begin hist_o[wr_o] = pd_o; wr_o++; end
    if (xb) rd_o += N_O;
    if (e) te_o++;
  endtask

  task automatic step_s(input logic e, input logic xa, input logic xb,
                        input string req);
    @(negedge clk);
    en_s = e;
    pd_s = 8'(wr_s * 5 + 17);
    #1;
    check(occ_s == 2'(wr_s - rd_s), "R7 serial occupancy", occ_s, wr_s - rd_s);
    check(err_s == 1'b0, "R8 serial error flag", err_s, 0);
    check(fa_s == xa, {req, " fire_a"}, fa_s, xa);
    check(fb_s == xb, {req, " fire_b"}, fb_s, xb);
    check(!(fa_s && fb_s), "R3 mutual exclusion", fa_s & fb_s, 0);
    if (xb) begin
      for (int k = 0; k < N_S; k++)
        check(cons_s[k*DW +: DW] == hist_s[rd_s + k], "R6 serial batch lane",
              cons_s[k*DW +: DW], hist_s[rd_s + k]);
    end
    @(posedge clk);
    if (xa) begin hist_s[wr_s] = pd_s; wr_s++; end
    if (xb) rd_s += N_S;
    if (e) te_s++;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en_o = 1'b0; en_s = 1'b0; pd_o = '0; pd_s = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(occ_o == 0 && occ_s == 0, "R1 reset occupancy", occ_o + occ_s, 0);
    check(err_o == 0 && err_s == 0, "R1 reset error", err_o | err_s, 0);
    check(!fa_o && !fb_o && !fa_s && !fb_s, "R1 no strobe in reset",
          fa_o | fb_o | fa_s | fb_s, 0);
    @(negedge clk);
    rst_n = 1'b1;

    step_o(1'b0, 1'b0, 1'b0, "R1 idle after reset");
    step_o(1'b0, 1'b0, 1'b0, "R1 idle after reset");

    // Table walk: overlapped schedule with enable gaps (R4, R5)
    for (int i = 0; i < 18; i++)
      step_o(VEC_O[i][2], VEC_O[i][1], VEC_O[i][0],
             (i == 0) ? "R2 first fire" : "R4 R5 vector");

    // Longer run, computed expectations, irregular enable (R4, R5)
    for (int t = 0; t < 40; t++) begin
      logic e;
      e = (t % 5 != 2);
      step_o(e, e, e && te_o >= N_O && (te_o % N_O) == 0, "R4 periodic run");
    end

    // Mid-run reset, restart from the producer alone (R1, R2)
    @(negedge clk);
    rst_n = 1'b0;
    en_o = 1'b0;
    #1;
    check(occ_o == 0, "R1 mid-run reset occupancy", occ_o, 0);
    check(err_o == 0, "R1 mid-run reset error", err_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    wr_o = 0; rd_o = 0; te_o = 0;
    wr_s = 0; rd_s = 0; te_s = 0;
    step_o(1'b1, 1'b1, 1'b0, "R2 first fire after reset");
    for (int t = 0; t < 10; t++)
      step_o(1'b1, 1'b1, te_o >= N_O && (te_o % N_O) == 0, "R4 restart");
    step_o(1'b0, 1'b0, 1'b0, "R5 overlapped idle");

    // Serial instance (R3), first enabled cycle fires producer (R2)
    for (int t = 0; t < 30; t++) begin
      logic e;
      e = (t % 7 != 6);
      step_s(e, e && (te_s % (N_S + 1)) != N_S,
             e && (te_s % (N_S + 1)) == N_S,
             (t == 0) ? "R2 serial first fire" : "R3 serial schedule");
    end

    check(err_o == 0 && err_s == 0, "R8 final error flags", err_o | err_s, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule